// File: doc/BRIEF.md
# CPU Clock and Power-Down Controller

This block derives the processor clock from the free-running system clock and sequences the low-power modes. The processor clock is delivered as a one-cycle enable strobe, `cpuClkEn`, that fires once every N system cycles. N is 4, 8 or 64, chosen by a 4-bit power control word. A new ratio is latched only when the current processor clock period ends, so no period is ever shortened or stretched to an odd length.

Two sleep commands are accepted while the processor runs:

- **Light sleep** (`idleCmd`) withholds only the processor strobe. The peripheral clock and the oscillator keep going.
- **Deep sleep** (`stopCmd`) drops the oscillator request. That also silences the peripheral clock and the divider.

Any enabled interrupt request on lines 1 and up ends either sleep. Line 0 is an external interrupt that never ends a sleep.

Leaving deep sleep restarts the oscillator, and reset does the same. In both cases the processor is held off for a fixed stabilization count of system cycles. The default count is 2^17, about 31.3 ms at 4.19 MHz. Waking from light sleep resumes the processor at once.

Top module: `cpu_clk_pm`

## Requirements
- R1: While reset is asserted and immediately after it, `cpuActive` and `periphClkEn` are 0, `oscRun` is 1, and the divide ratio is 64.
- R2: After reset is released, `cpuActive` stays 0 for STAB_CYCLES-1 rising clock edges and becomes 1 after edge STAB_CYCLES.
- R3: `pcrData[1:0]` written with `pcrWe` selects the ratio: 2'b00 gives 64, 2'b01 gives 8, 2'b10 gives 4 and 2'b11 gives 64. `pcrData[3:2]` has no effect. While running, `cpuClkEn` pulses once every ratio system cycles.
- R4: A ratio write made in the middle of a processor clock period lets that period finish at the old length. The next period uses the new length.
- R5: `cpuClkEn` is a single-cycle pulse and is only ever 1 while `cpuActive` is 1.
- R6: `idleCmd` while running enters light sleep at the next edge. There `cpuActive` is 0, no `cpuClkEn` pulses occur, and `oscRun` and `periphClkEn` stay 1.
- R7: `stopCmd` while running enters deep sleep at the next edge. There `oscRun`, `periphClkEn`, `cpuActive` and `cpuClkEn` are all 0.
- R8: In light sleep, a request on any `wakeReq` bit other than bit 0 sets `cpuActive` at the next edge, with no stabilization wait.
- R9: In deep sleep, a request on any `wakeReq` bit other than bit 0 sets `oscRun` at the next edge. `cpuActive` then rises STAB_CYCLES edges later.
- R10: `wakeReq[0]` alone never ends light or deep sleep.
- R11: When `stopCmd` and `idleCmd` are asserted together while running, deep sleep is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (fx) |
| rst_n | input | 1 | Active-low reset |
| pcrWe | input | 1 | Write strobe for the power control word |
| pcrData | input | 4 | Power control word; bits 1:0 select the divide ratio |
| idleCmd | input | 1 | Request light sleep |
| stopCmd | input | 1 | Request deep sleep |
| wakeReq | input | NIRQ | Enabled pending interrupts; bit 0 is the non-waking external line |
| cpuClkEn | output | 1 | Processor clock enable strobe |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscRun | output | 1 | Oscillator run request |
| cpuActive | output | 1 | Processor is running (not asleep, not stabilizing) |

## Verification
A corrupted divider counter or a stale ratio register shows up as a `cpuClkEn` interval of the wrong length within one processor period. The bench measures every interval against the ratio computed from the written code, sweeping all sixteen codes. A mis-stepped mode state appears as a wrong combination of `oscRun`, `periphClkEn` and `cpuActive` one edge after the command or wake request. A miscounted stabilization counter moves the rise of `cpuActive` off its exact edge, which is sampled one cycle before and at the expected edge.

// File: rtl/cpu_clk_pm_pkg.sv
package cpu_clk_pm_pkg;

  typedef enum logic [1:0] {
    PM_WAIT = 2'd0,
    PM_RUN  = 2'd1,
    PM_IDLE = 2'd2,
    PM_STOP = 2'd3
  } pmState_t;

  typedef struct packed {
    logic divRun;
    logic cpuGate;
  } pmStrobe_t;

endpackage

// File: rtl/cpu_clk_pm_ctrl.sv
module cpu_clk_pm_ctrl
  import cpu_clk_pm_pkg::*;
#(
  parameter int NIRQ        = 4,
  parameter int STAB_CYCLES = 131072
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idleCmd,
  input  logic            stopCmd,
  input  logic [NIRQ-1:0] wakeReq,
  output pmStrobe_t       strobe,
  output logic            cpuActive,
  output logic            periphClkEn,
  output logic            oscRun
);

  localparam int SW = $clog2(STAB_CYCLES);
  localparam logic [SW-1:0] STAB_LAST = SW'(STAB_CYCLES - 1);

  pmState_t      state;
  logic [SW-1:0] stabCnt;
  logic          wake;
  logic          unusedInt0;

  // line 0 is excluded from waking
  assign wake       = |wakeReq[NIRQ-1:1];
  assign unusedInt0 = wakeReq[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PM_WAIT;
      stabCnt <= '0;
    end else begin
      case (state)
        PM_WAIT: begin
          if (stabCnt == STAB_LAST) begin
            state   <= PM_RUN;
            stabCnt <= '0;
          end else begin
            stabCnt <= stabCnt + 1'b1;
          end
        end
        PM_RUN: begin
          if (stopCmd)      state <= PM_STOP;
          else if (idleCmd) state <= PM_IDLE;
        end
        PM_IDLE: begin
          if (wake) state <= PM_RUN;
        end
        default: begin
          if (wake) begin
            state   <= PM_WAIT;
            stabCnt <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.divRun  = (state != PM_STOP);
    strobe.cpuGate = (state == PM_RUN);
  end

  assign cpuActive   = (state == PM_RUN);
  assign periphClkEn = (state == PM_RUN) || (state == PM_IDLE);
  assign oscRun      = (state != PM_STOP);

endmodule

// File: rtl/cpu_clk_pm_div.sv
module cpu_clk_pm_div
  import cpu_clk_pm_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 64,
  localparam int CW      = $clog2(DIV_SLOW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pcrWe,
  input  logic [1:0]    pcrSel,
  input  pmStrobe_t     strobe,
  output logic          tick,
  output logic          cpuClkEn,
  output logic [CW-1:0] curLast
);

  logic [1:0]    selReg;
  logic [CW-1:0] divCnt;

  function automatic logic [CW-1:0] lastFor(input logic [1:0] s);
    case (s)
      2'b01:   return CW'(DIV_MID - 1);
      2'b10:   return CW'(DIV_FAST - 1);
      default: return CW'(DIV_SLOW - 1);
    endcase
  endfunction

  assign tick     = strobe.divRun && (divCnt == curLast);
  assign cpuClkEn = tick && strobe.cpuGate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selReg  <= 2'b00;
      curLast <= CW'(DIV_SLOW - 1);
      divCnt  <= '0;
    end else begin
      if (pcrWe) selReg <= pcrSel;
      if (!strobe.divRun) begin
        divCnt <= '0;
      end else if (tick) begin
        divCnt  <= '0;
        curLast <= lastFor(selReg);
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cpu_clk_pm.sv
module cpu_clk_pm
  import cpu_clk_pm_pkg::*;
#(
  parameter int NIRQ        = 4,
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 8,
  parameter int DIV_SLOW    = 64,
  parameter int STAB_CYCLES = 131072
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pcrWe,
  input  logic [3:0]      pcrData,
  input  logic            idleCmd,
  input  logic            stopCmd,
  input  logic [NIRQ-1:0] wakeReq,
  output logic            cpuClkEn,
  output logic            periphClkEn,
  output logic            oscRun,
  output logic            cpuActive
);

  localparam int CW = $clog2(DIV_SLOW);

  pmStrobe_t     strobe;
  logic          tickW;
  logic [CW-1:0] curLastW;
  logic          unusedPcrHi;

  assign unusedPcrHi = ^pcrData[3:2];

  cpu_clk_pm_ctrl #(.NIRQ(NIRQ), .STAB_CYCLES(STAB_CYCLES)) ctrlI (
    .clk(clk), .rst_n(rst_n), .idleCmd(idleCmd), .stopCmd(stopCmd),
    .wakeReq(wakeReq), .strobe(strobe), .cpuActive(cpuActive),
    .periphClkEn(periphClkEn), .oscRun(oscRun)
  );

  cpu_clk_pm_div #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) divI (
    .clk(clk), .rst_n(rst_n), .pcrWe(pcrWe), .pcrSel(pcrData[1:0]),
    .strobe(strobe), .tick(tickW), .cpuClkEn(cpuClkEn), .curLast(curLastW)
  );

endmodule

// File: rtl/cpu_clk_pm_chk.sv
module cpu_clk_pm_chk #(
  parameter int NIRQ = 4,
  parameter int CW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpuClkEn,
  input logic            cpuActive,
  input logic            periphClkEn,
  input logic            oscRun,
  input logic [NIRQ-1:0] wakeReq,
  input logic [CW-1:0]   curLast,
  input logic            tick
);

  logic idleNow;
  assign idleNow = oscRun && periphClkEn && !cpuActive;

  // R5
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuClkEn |-> cpuActive);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpuClkEn |=> !cpuClkEn);

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oscRun |-> (!periphClkEn && !cpuClkEn && !cpuActive));

  // R10
  int0_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oscRun && (wakeReq[NIRQ-1:1] == '0)) |=> !oscRun);

  // R10
  int0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idleNow && (wakeReq[NIRQ-1:1] == '0)) |=> !cpuActive);

  // R8
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idleNow && (wakeReq[NIRQ-1:1] != '0)) |=> cpuActive);

  // R4
  ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curLast != $past(curLast)) |-> $past(tick));

  // R9
  stop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oscRun) |-> !cpuActive);

endmodule

bind cpu_clk_pm cpu_clk_pm_chk #(.NIRQ(NIRQ), .CW(CW)) chkI (
  .clk(clk), .rst_n(rst_n), .cpuClkEn(cpuClkEn), .cpuActive(cpuActive),
  .periphClkEn(periphClkEn), .oscRun(oscRun), .wakeReq(wakeReq),
  .curLast(curLastW), .tick(tickW)
);

// File: tb/cpu_clk_pm_test.sv
module cpu_clk_pm_test;

  localparam int CLK_P = 10;
  localparam int NIRQ  = 4;
  localparam int STAB  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pcrWe = 1'b0;
  logic [3:0] pcrData = 4'd0;
  logic idleCmd = 1'b0;
  logic stopCmd = 1'b0;
  logic [NIRQ-1:0] wakeReq = '0;
  logic cpuClkEn, periphClkEn, oscRun, cpuActive;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpu_clk_pm #(.NIRQ(NIRQ), .STAB_CYCLES(STAB)) uut (
    .clk(clk), .rst_n(rst_n), .pcrWe(pcrWe), .pcrData(pcrData),
    .idleCmd(idleCmd), .stopCmd(stopCmd), .wakeReq(wakeReq),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscRun(oscRun),
    .cpuActive(cpuActive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ratioOf(input logic [3:0] v);
    case (v[1:0])
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 64;
    endcase
  endfunction

  task automatic waitPulse(output int t);
    do @(negedge clk); while (!cpuClkEn);
    t = cyc;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, t1, t2, pulses, oldR;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(oscRun == 1 && cpuActive == 0 && periphClkEn == 0, "R1", "reset outputs",
          {oscRun, cpuActive, periphClkEn}, 3'b100);
    rst_n = 1'b1;
    // R2 exact rise of cpuActive
    repeat (STAB - 1) @(negedge clk);
    check(cpuActive == 0, "R2", "active one edge early", cpuActive, 0);
    @(negedge clk);
    check(cpuActive == 1, "R2", "active at count end", cpuActive, 1);
    // R1 default ratio 64
    waitPulse(t0);
    waitPulse(t1);
    check(t1 - t0 == 64, "R1", "default period", t1 - t0, 64);
    oldR = 64;
    // R3 and R4: sweep all sixteen control codes
    for (int v = 0; v < 16; v++) begin
      waitPulse(t0);
      @(negedge clk);
      pcrWe = 1'b1;
      pcrData = 4'(v);
      @(negedge clk);
      pcrWe = 1'b0;
      waitPulse(t1);
      check(t1 - t0 == oldR, "R4", "period holding the write", t1 - t0, oldR);
      waitPulse(t2);
      check(t2 - t1 == ratioOf(4'(v)), "R3", "period after write", t2 - t1, ratioOf(4'(v)));
      oldR = ratioOf(4'(v));
    end
    // R5 pulses only one cycle wide (ratio now 64)
    waitPulse(t0);
    @(negedge clk);
    check(cpuClkEn == 0, "R5", "pulse width", cpuClkEn, 0);
    // set ratio 4 for the rest
    pcrWe = 1'b1; pcrData = 4'b1110;
    @(negedge clk);
    pcrWe = 1'b0;
    repeat (140) @(negedge clk);
    // R6 light sleep
    idleCmd = 1'b1;
    @(negedge clk);
    idleCmd = 1'b0;
    check(cpuActive == 0 && periphClkEn == 1 && oscRun == 1, "R6", "idle outputs",
          {cpuActive, periphClkEn, oscRun}, 3'b011);
    // R10 line 0 does not wake light sleep; R6 no strobes
    wakeReq = 4'b0001;
    pulses = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (cpuClkEn) pulses++;
    end
    check(pulses == 0, "R6", "strobes in idle", pulses, 0);
    check(cpuActive == 0, "R10", "int0 woke idle", cpuActive, 0);
    // R8 wake from idle immediately
    wakeReq = 4'b0010;
    @(negedge clk);
    wakeReq = '0;
    check(cpuActive == 1, "R8", "idle wake", cpuActive, 1);
    waitPulse(t0);
    waitPulse(t1);
    check(t1 - t0 == 4, "R8", "period after idle wake", t1 - t0, 4);
    // R11 both commands -> deep sleep; R7 outputs
    @(negedge clk);
    idleCmd = 1'b1; stopCmd = 1'b1;
    @(negedge clk);
    idleCmd = 1'b0; stopCmd = 1'b0;
    check(oscRun == 0, "R11", "stop wins over idle", oscRun, 0);
    check(periphClkEn == 0 && cpuActive == 0 && cpuClkEn == 0, "R7", "stop outputs",
          {periphClkEn, cpuActive, cpuClkEn}, 0);
    // R10 line 0 does not wake deep sleep
    wakeReq = 4'b0001;
    repeat (30) @(negedge clk);
    check(oscRun == 0, "R10", "int0 woke stop", oscRun, 0);
    // R9 wake from stop with stabilization
    wakeReq = 4'b1000;
    @(negedge clk);
    wakeReq = '0;
    check(oscRun == 1 && cpuActive == 0, "R9", "osc restart, cpu held",
          {oscRun, cpuActive}, 2'b10);
    repeat (STAB - 1) @(negedge clk);
    check(cpuActive == 0, "R9", "active one edge early", cpuActive, 0);
    @(negedge clk);
    check(cpuActive == 1, "R9", "active after count", cpuActive, 1);
    // direct deep sleep entry, R7
    idleCmd = 1'b0; stopCmd = 1'b1;
    @(negedge clk);
    stopCmd = 1'b0;
    check(oscRun == 0 && periphClkEn == 0, "R7", "stop only command",
          {oscRun, periphClkEn}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule